// File: doc/BRIEF.md
# Serial RAM Target Port (single-line and four-line)

This block is the device side of a serial RAM link. It oversamples a chip select, a serial clock and four data lines with the system clock. Each chip-select-low period is one transaction. The transaction starts with a one-byte opcode, then a 24-bit byte address, then an opcode-specific number of idle clocks. After that come data bytes, which are written into or read from an internal byte array. The array depth is set by a parameter, and only the low address bits are used.

The port runs in one of two operating modes. In single-line mode, the opcode always arrives one bit per clock on line 0. In four-line mode, every phase moves one nibble per clock. Some opcodes use four-line address and data even in single-line mode. Mode changes and the two-step software reset only take effect when chip select is released. Reads also return a fixed identification sequence on request. Output data goes out on `dq_out` with per-line enables in `dq_oe`, and the enables are removed as soon as `cs_n` goes high.

Top module: `sqram_target`

## Requirements
- R1: After `rst_n`, the port is in single-line mode. Until `cs_n` has been seen high once, all serial activity is ignored.
- R2: Opcode 0x02 writes and opcode 0x03 reads, with all phases single-line. Inputs are taken on line 0 and outputs driven on line 1, most significant bit first. Enables are 4'b0010 while driving. The address is three bytes, most significant first. 0x03 has no idle clocks and is not accepted in four-line mode.
- R3: Opcode 0x0B reads with 8 idle clocks in single-line mode (all phases single-line). In four-line mode it has 4 idle clocks (all phases four-line).
- R4: Opcode 0xEB reads with four-line address and data and 6 idle clocks in both modes. A nibble carries byte bits [7:4] first, then [3:0], with bit 3 of the nibble on line 3. Enables are 4'b1111 while driving.
- R5: Opcode 0x38 writes with four-line address and data in single-line mode. In four-line mode, 0x02 and 0x38 behave identically.
- R6: Opcode 0x35 selects four-line mode and is accepted only in single-line mode. Opcode 0xF5 selects single-line mode and is accepted only in four-line mode. Both take effect when `cs_n` rises.
- R7: Opcode 0x9F is accepted only in single-line mode. It takes a single-line address, has no idle clocks, and returns the bytes of `ID_VALUE`, highest byte first, repeating. In four-line mode it drives nothing.
- R8: Opcode 0x66 arms a reset. The reset is carried out by opcode 0x99 in the very next transaction, which returns the port to single-line mode at `cs_n` rise. Any other transaction in between disarms it, and 0x99 without arming has no effect.
- R9: Bursts advance the byte address by one per byte. They cross 1 KB boundaries and wrap at the top of the array.
- R10: `dq_oe` is zero while `cs_n` is high, including directly after a rise in mid-burst.
- R11: An unknown opcode drives no output, writes nothing and leaves the mode unchanged until `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock; inputs taken on its rise, outputs launched after its fall |
| cs_n | input | 1 | Active-low chip select framing one transaction |
| dq_in | input | 4 | Data lines as seen at the pad inputs |
| dq_out | output | 4 | Data driven toward the pads |
| dq_oe | output | 4 | Per-line output enable |

## Verification
If a wait count or phase width is wrong, every returned byte shifts by the same number of bits. This shows up on the first data byte of the very next read. If the mode flag is wrong, the next transaction is decoded at the wrong width: a read then drives nothing, or returns the wrong nibbles, within a few serial clocks. A wrong reset-arm state is only visible after a 0x99 transaction, through the width of the transaction that follows. The bench therefore always places a read right after each mode or reset step.

// File: rtl/sqram_pkg.sv
// Shared opcodes, phase/action types and the opcode decoder for the
// serial RAM target port. Assumes an 8-bit opcode and a 24-bit address.
package sqram_pkg;

    localparam logic [7:0] OPC_RD_SLOW  = 8'h03;
    localparam logic [7:0] OPC_RD_FAST  = 8'h0B;
    localparam logic [7:0] OPC_RD_WIDE  = 8'hEB;
    localparam logic [7:0] OPC_WR       = 8'h02;
    localparam logic [7:0] OPC_WR_WIDE  = 8'h38;
    localparam logic [7:0] OPC_GO_QUAD  = 8'h35;
    localparam logic [7:0] OPC_GO_SER   = 8'hF5;
    localparam logic [7:0] OPC_ARM      = 8'h66;
    localparam logic [7:0] OPC_FIRE     = 8'h99;
    localparam logic [7:0] OPC_IDENT    = 8'h9F;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD, PH_ADDR, PH_WAIT, PH_RDATA, PH_WDATA, PH_SKIP
    } phase_t;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_QUAD_ON, ACT_QUAD_OFF, ACT_ARM, ACT_FIRE
    } act_t;

    typedef struct packed {
        logic       is_read;
        logic       is_write;
        logic       is_id;
        logic       quad;
        logic [3:0] waits;
        act_t       act;
    } decode_t;

    // Maps an opcode and the current mode to the transaction shape.
    function automatic decode_t decode_op(input logic [7:0] op, input logic in_quad);
        decode_t d;
        d = '0;
        d.act = ACT_NONE;
        case (op)
            OPC_RD_SLOW: if (!in_quad) d.is_read = 1'b1;
            OPC_RD_FAST: begin
                d.is_read = 1'b1;
                d.quad    = in_quad;
                d.waits   = in_quad ? 4'd4 : 4'd8;
            end
            OPC_RD_WIDE: begin
                d.is_read = 1'b1;
                d.quad    = 1'b1;
                d.waits   = 4'd6;
            end
            OPC_WR: begin
                d.is_write = 1'b1;
                d.quad     = in_quad;
            end
            OPC_WR_WIDE: begin
                d.is_write = 1'b1;
                d.quad     = 1'b1;
            end
            OPC_GO_QUAD: if (!in_quad) d.act = ACT_QUAD_ON;
            OPC_GO_SER:  if (in_quad)  d.act = ACT_QUAD_OFF;
            OPC_ARM:     d.act = ACT_ARM;
            OPC_FIRE:    d.act = ACT_FIRE;
            OPC_IDENT: if (!in_quad) begin
                d.is_read = 1'b1;
                d.is_id   = 1'b1;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sqram_pad_sync.sv
// Brings the asynchronous serial pins into the system clock domain and
// produces one-cycle edge strobes. Assumes the serial clock half period is
// several system clocks long. Data lines share the same pipeline depth,
// so a sampled nibble lines up with the serial clock rise detected alongside it.
module sqram_pad_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic [3:0] dq_in,
    output logic       sclk_rise,
    output logic       sclk_fall,
    output logic       cs_rise,
    output logic       cs_fall,
    output logic       cs_level,
    output logic [3:0] dq_s
);
    localparam int DQ_W = 4 * STAGES;

    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] cs_pipe;
    logic [DQ_W-1:0]   dq_pipe;
    logic              sclk_prev;
    logic              cs_prev;

    // Shift pins through the synchronizer and keep the previous stable value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            cs_pipe   <= '0;
            dq_pipe   <= '0;
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b0;
        end else begin
            sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk};
            cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n};
            dq_pipe   <= {dq_pipe[DQ_W-5:0], dq_in};
            sclk_prev <= sclk_pipe[STAGES-1];
            cs_prev   <= cs_pipe[STAGES-1];
        end
    end

    assign sclk_rise = sclk_pipe[STAGES-1] & ~sclk_prev;
    assign sclk_fall = ~sclk_pipe[STAGES-1] & sclk_prev;
    assign cs_rise   = cs_pipe[STAGES-1] & ~cs_prev;
    assign cs_fall   = ~cs_pipe[STAGES-1] & cs_prev;
    assign cs_level  = cs_pipe[STAGES-1];
    assign dq_s      = dq_pipe[DQ_W-1 -: 4];

endmodule

// File: rtl/sqram_byte_array.sv
// Byte-wide storage with one synchronous write and one registered read
// of the same address. Contents are not cleared by reset.
module sqram_byte_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Store on write strobe and register the addressed byte every cycle.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end

endmodule

// File: rtl/sqram_seq.sv
// Transaction sequencer: opcode, address, idle and data phases, the
// single-line/four-line mode flag and the armed reset. Acts on the edge
// strobes from sqram_pad_sync. Assumes ADDR_W <= 24 and that the read
// array returns data two system clocks after an address change.
module sqram_seq
    import sqram_pkg::*;
#(
    parameter int                    ADDR_W   = 11,
    parameter int                    ID_BYTES = 2,
    parameter logic [8*ID_BYTES-1:0] ID_VALUE = 16'hC35A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              cs_level,
    input  logic [3:0]        dq_s,
    input  logic [7:0]        rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [3:0]        out_nib,
    output logic [3:0]        oe_nib
);
    localparam int IDX_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

    phase_t            phase;
    decode_t           dec;
    act_t              pend_act;
    logic              quad_q;
    logic              armed_q;
    logic              seen_high;
    logic [7:0]        op_sr;
    logic [4:0]        cnt;
    logic [23:0]       addr_sr;
    logic [3:0]        waits_left;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [7:0]        wdata_q;
    logic [7:0]        wbyte_sr;
    logic [7:0]        cur_byte;
    logic [2:0]        pos;
    logic [1:0]        fetch_q;
    logic [IDX_W-1:0]  id_idx;
    logic [3:0]        oe_q;
    logic [3:0]        out_q;

    logic              wide_now;
    logic [4:0]        cnt_nxt;
    logic [7:0]        nxt_op;
    logic [23:0]       nxt_addr;
    logic [7:0]        nxt_w;
    decode_t           dec_now;
    logic              rd_last;
    int                id_base;
    logic [7:0]        id_byte;

    // Shift-in helpers: width of the current phase and the next register values.
    always_comb begin
        wide_now = (phase == PH_CMD) ? quad_q : dec.quad;
        cnt_nxt  = cnt + (wide_now ? 5'd4 : 5'd1);
        nxt_op   = quad_q   ? {op_sr[3:0], dq_s}     : {op_sr[6:0], dq_s[0]};
        nxt_addr = dec.quad ? {addr_sr[19:0], dq_s}  : {addr_sr[22:0], dq_s[0]};
        nxt_w    = dec.quad ? {wbyte_sr[3:0], dq_s}  : {wbyte_sr[6:0], dq_s[0]};
        dec_now  = decode_op(nxt_op, quad_q);
        rd_last  = dec.quad ? (pos == 3'd1) : (pos == 3'd7);
        id_base  = (ID_BYTES - 1 - int'(id_idx)) * 8;
        id_byte  = ID_VALUE[id_base +: 8];
    end

    // Record that chip select has been observed high since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen_high <= 1'b0;
        else if (cs_level) seen_high <= 1'b1;
    end

    // Phase machine, address counter, write strobe and output drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            dec        <= '0;
            pend_act   <= ACT_NONE;
            op_sr      <= '0;
            cnt        <= '0;
            addr_sr    <= '0;
            waits_left <= '0;
            addr_q     <= '0;
            we_q       <= 1'b0;
            wdata_q    <= '0;
            wbyte_sr   <= '0;
            pos        <= '0;
            fetch_q    <= '0;
            id_idx     <= '0;
            oe_q       <= '0;
            out_q      <= '0;
        end else begin
            we_q    <= 1'b0;
            fetch_q <= {fetch_q[0], 1'b0};
            if (we_q) addr_q <= addr_q + 1'b1;
            if (cs_rise) begin
                phase    <= PH_IDLE;
                oe_q     <= '0;
                pend_act <= ACT_NONE;
            end else begin
                case (phase)
                    PH_IDLE: if (cs_fall && seen_high) begin
                        phase <= PH_CMD;
                        cnt   <= '0;
                        op_sr <= '0;
                    end
                    PH_CMD: if (sclk_rise) begin
                        op_sr <= nxt_op;
                        if (cnt_nxt == 5'd8) begin
                            dec      <= dec_now;
                            cnt      <= '0;
                            pend_act <= dec_now.act;
                            id_idx   <= '0;
                            phase    <= (dec_now.is_read || dec_now.is_write) ? PH_ADDR : PH_SKIP;
                        end else begin
                            cnt <= cnt_nxt;
                        end
                    end
                    PH_ADDR: if (sclk_rise) begin
                        addr_sr <= nxt_addr;
                        if (cnt_nxt == 5'd24) begin
                            cnt        <= '0;
                            addr_q     <= nxt_addr[ADDR_W-1:0];
                            waits_left <= dec.waits;
                            if (dec.is_write) begin
                                phase <= PH_WDATA;
                            end else if (dec.waits == 4'd0) begin
                                phase   <= PH_RDATA;
                                fetch_q <= 2'b01;
                                pos     <= '0;
                            end else begin
                                phase <= PH_WAIT;
                            end
                        end else begin
                            cnt <= cnt_nxt;
                        end
                    end
                    PH_WAIT: if (sclk_rise) begin
                        waits_left <= waits_left - 4'd1;
                        if (waits_left == 4'd1) begin
                            phase   <= PH_RDATA;
                            fetch_q <= 2'b01;
                            pos     <= '0;
                        end
                    end
                    PH_RDATA: if (sclk_fall) begin
                        oe_q  <= dec.quad ? 4'b1111 : 4'b0010;
                        out_q <= dec.quad ? (pos[0] ? cur_byte[3:0] : cur_byte[7:4])
                                          : {2'b00, cur_byte[3'd7 - pos], 1'b0};
                        if (rd_last) begin
                            pos     <= '0;
                            addr_q  <= addr_q + 1'b1;
                            id_idx  <= (id_idx == IDX_W'(ID_BYTES - 1)) ? '0 : id_idx + 1'b1;
                            fetch_q <= 2'b01;
                        end else begin
                            pos <= pos + 3'd1;
                        end
                    end
                    PH_WDATA: if (sclk_rise) begin
                        wbyte_sr <= nxt_w;
                        if (cnt_nxt == 5'd8) begin
                            cnt     <= '0;
                            we_q    <= 1'b1;
                            wdata_q <= nxt_w;
                        end else begin
                            cnt <= cnt_nxt;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Load the next outgoing byte once the array read has settled.
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_byte <= '0;
        else if (fetch_q[1]) cur_byte <= dec.is_id ? id_byte : rdata;
    end

    // Apply mode changes and the armed reset only at chip select release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quad_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (cs_rise) begin
            armed_q <= (pend_act == ACT_ARM);
            case (pend_act)
                ACT_QUAD_ON:  quad_q <= 1'b1;
                ACT_QUAD_OFF: quad_q <= 1'b0;
                ACT_FIRE:     if (armed_q) quad_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign mem_we    = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign out_nib   = out_q;
    assign oe_nib    = oe_q;

    // Nothing leaves idle before chip select has been high once.
    assert_wait_for_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_high |-> (phase == PH_IDLE));

    // Drive shape is one of the two legal patterns.
    assert_oe_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q != 4'b0000) |-> (oe_q == 4'b1111 || oe_q == 4'b0010));

    // The mode flag moves only at a chip select release.
    assert_mode_at_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(quad_q));

    // Arming survives only a release that closed a reset-enable transaction.
    assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && pend_act != ACT_ARM) |=> !armed_q);

    // Each stored byte advances the address by exactly one.
    assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr == $past(mem_addr) + 1'b1));

    // Internal drive is dropped right after release is seen.
    assert_oe_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (oe_q == 4'b0000));

endmodule

// File: rtl/sqram_target.sv
// Top of the serial RAM target port: pad synchronizer, sequencer and
// byte array. Output enables are also gated directly by the chip select
// pin, so they are released with no synchronizer delay.
module sqram_target #(
    parameter int                    ADDR_W      = 11,
    parameter int                    SYNC_STAGES = 2,
    parameter int                    ID_BYTES    = 2,
    parameter logic [8*ID_BYTES-1:0] ID_VALUE    = 16'hC35A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic [3:0] dq_in,
    output logic [3:0] dq_out,
    output logic [3:0] dq_oe
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic              cs_rise;
    logic              cs_fall;
    logic              cs_level;
    logic [3:0]        dq_s;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;
    logic [3:0]        oe_nib;

    sqram_pad_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .dq_in(dq_in),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_rise(cs_rise),
        .cs_fall(cs_fall), .cs_level(cs_level), .dq_s(dq_s)
    );

    sqram_seq #(.ADDR_W(ADDR_W), .ID_BYTES(ID_BYTES), .ID_VALUE(ID_VALUE)) seq_i (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_rise(cs_rise), .cs_fall(cs_fall), .cs_level(cs_level), .dq_s(dq_s),
        .rdata(mem_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .out_nib(dq_out), .oe_nib(oe_nib)
    );

    sqram_byte_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
    );

    assign dq_oe = oe_nib & {4{~cs_n}};

endmodule

// File: tb/sqram_target_tb_top.sv
// Bench: directed corner cases plus seeded random bursts, checked against a byte model.
module sqram_target_tb_top;
    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] dq_in = 4'h0;
    logic [3:0] dq_out;
    logic [3:0] dq_oe;

    int   vectors = 0;
    int   fails = 0;
    bit   done = 1'b0;
    bit   m_quad = 1'b0;
    logic [7:0] model [DEPTH];

    always #2 clk = ~clk;

    sqram_target #(.ADDR_W(ADDR_W), .ID_BYTES(2), .ID_VALUE(16'hC35A)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic int idx(input logic [23:0] a, input int i);
        return (int'(a) + i) % DEPTH;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_unit(input logic [3:0] v);
        dq_in = v;
        wait_n(6);
        sclk = 1'b1;
        wait_n(6);
        sclk = 1'b0;
    endtask

    task automatic get_unit(output logic [3:0] v, output logic [3:0] oe);
        wait_n(5);
        v  = dq_out;
        oe = dq_oe;
        wait_n(1);
        sclk = 1'b1;
        wait_n(6);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit wide);
        if (wide) begin
            put_unit(b[7:4]);
            put_unit(b[3:0]);
        end else begin
            for (int i = 7; i >= 0; i--) put_unit({3'b000, b[i]});
        end
    endtask

    task automatic send_addr(input logic [23:0] a, input bit wide);
        send_byte(a[23:16], wide);
        send_byte(a[15:8], wide);
        send_byte(a[7:0], wide);
    endtask

    task automatic get_byte(input bit wide, output logic [7:0] b, output logic [3:0] oe);
        logic [3:0] v;
        if (wide) begin
            get_unit(v, oe); b[7:4] = v;
            get_unit(v, oe); b[3:0] = v;
        end else begin
            for (int i = 7; i >= 0; i--) begin
                get_unit(v, oe);
                b[i] = v[1];
            end
        end
    endtask

    task automatic cs_start();
        wait_n(1);
        cs_n = 1'b0;
        wait_n(6);
    endtask

    task automatic cs_end(input bit chk_oe);
        wait_n(2);
        cs_n = 1'b1;
        #1;
        if (chk_oe) check("R10 oe at release", {28'd0, dq_oe}, 32'd0);
        wait_n(10);
    endtask

    task automatic simple_op(input logic [7:0] op);
        cs_start();
        send_byte(op, m_quad);
        cs_end(1'b0);
    endtask

    task automatic do_write(input logic [7:0] op, input logic [23:0] a, input int n, input bit upd);
        bit wide;
        logic [7:0] b;
        wide = m_quad || (op == 8'h38);
        cs_start();
        send_byte(op, m_quad);
        send_addr(a, wide);
        for (int i = 0; i < n; i++) begin
            b = 8'($urandom);
            send_byte(b, wide);
            if (upd) model[idx(a, i)] = b;
        end
        cs_end(1'b0);
    endtask

    task automatic do_read(input string req, input logic [7:0] op, input logic [23:0] a, input int n);
        bit wide;
        int waits;
        logic [7:0] b;
        logic [3:0] oe;
        wide  = m_quad || (op == 8'hEB);
        waits = (op == 8'h0B) ? (m_quad ? 4 : 8) : ((op == 8'hEB) ? 6 : 0);
        cs_start();
        send_byte(op, m_quad);
        send_addr(a, wide);
        for (int i = 0; i < waits; i++) put_unit(4'h0);
        for (int i = 0; i < n; i++) begin
            get_byte(wide, b, oe);
            check(req, {24'd0, b}, {24'd0, model[idx(a, i)]});
            check({req, " oe"}, {28'd0, oe}, wide ? 32'hF : 32'h2);
        end
        cs_end(1'b1);
    endtask

    // Serial-mode opcode with trailing traffic; the port must stay silent.
    task automatic silent_op(input string req, input logic [7:0] op, input int units);
        logic [3:0] v, oe;
        cs_start();
        send_byte(op, m_quad);
        send_addr(24'h000005, m_quad);
        for (int i = 0; i < units; i++) begin
            dq_in = 4'(i);
            get_unit(v, oe);
            check(req, {28'd0, oe}, 32'd0);
        end
        cs_end(1'b0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] b;
        logic [3:0] oe;
        void'($urandom(32'd1357));
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        check("R1 oe after reset", {28'd0, dq_oe}, 32'd0);

        // R2: serial write then slow serial read, default single-line mode
        do_write(8'h02, 24'h000005, 1, 1'b1);
        do_read("R2 serial read", 8'h03, 24'h000005, 1);

        // R1: chip select low through reset blocks everything until it rises
        rst_n = 1'b0;
        cs_n  = 1'b0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(4);
        send_byte(8'h02, 1'b0);
        send_addr(24'h000005, 1'b0);
        send_byte(8'h3C, 1'b0);
        cs_end(1'b0);
        do_read("R1 gated write ignored", 8'h03, 24'h000005, 1);

        // R6/R5/R9: four-line mode, full fill crossing 1 KB and wrapping
        simple_op(8'h35);
        m_quad = 1'b1;
        do_write(8'h02, 24'h0007F8, DEPTH, 1'b1);
        do_read("R9 page cross R4", 8'hEB, 24'hAB03FC, 8);
        do_read("R9 wrap R3 quad waits", 8'h0B, 24'h0007FC, 8);
        do_write(8'h38, 24'h000100, 3, 1'b1);
        do_read("R5 wide write in quad", 8'h0B, 24'h000100, 3);

        // R6: entry opcode in four-line mode is ignored, exit works
        simple_op(8'h35);
        do_read("R6 stay quad", 8'h0B, 24'h000200, 2);
        simple_op(8'hF5);
        m_quad = 1'b0;
        do_read("R3 serial waits", 8'h0B, 24'h000210, 3);
        simple_op(8'hF5);
        do_read("R6 exit ignored in serial", 8'h03, 24'h000220, 2);

        // R5/R4: wide write and wide read from single-line mode
        do_write(8'h38, 24'h00012C, 4, 1'b1);
        do_read("R4 wide read in serial", 8'hEB, 24'h00012C, 4);

        // R7: identification bytes, then rejection in four-line mode
        cs_start();
        send_byte(8'h9F, 1'b0);
        send_addr(24'h123456, 1'b0);
        for (int i = 0; i < 3; i++) begin
            get_byte(1'b0, b, oe);
            check("R7 id byte", {24'd0, b}, (i % 2 == 0) ? 32'hC3 : 32'h5A);
        end
        cs_end(1'b1);
        simple_op(8'h35);
        m_quad = 1'b1;
        silent_op("R7 id rejected in quad", 8'h9F, 6);
        do_read("R7 quad intact", 8'hEB, 24'h000300, 2);

        // R8: armed reset returns to single-line mode
        simple_op(8'h66);
        simple_op(8'h99);
        m_quad = 1'b0;
        do_read("R8 reset to serial", 8'h03, 24'h000310, 2);

        // R8: disarm by an intervening transaction, and fire without arming
        simple_op(8'h35);
        m_quad = 1'b1;
        simple_op(8'h66);
        simple_op(8'h05);
        simple_op(8'h99);
        do_read("R8 disarmed stays quad", 8'h0B, 24'h000320, 2);
        simple_op(8'h99);
        do_read("R8 unarmed fire no effect", 8'hEB, 24'h000330, 2);
        simple_op(8'h66);
        simple_op(8'h99);
        m_quad = 1'b0;

        // R11: unknown opcode in serial mode drives nothing, writes nothing
        silent_op("R11 unknown silent", 8'hA7, 16);
        do_read("R11 no write, mode kept", 8'h03, 24'h000005, 4);

        // Random mix across both modes
        for (int k = 0; k < 40; k++) begin
            int r;
            logic [23:0] a;
            int n;
            r = int'($urandom % 10);
            a = 24'($urandom);
            n = 1 + int'($urandom % 6);
            if (r == 0) begin
                simple_op(m_quad ? 8'hF5 : 8'h35);
                m_quad = !m_quad;
            end else if (r < 4) begin
                do_write(($urandom % 2 == 0) ? 8'h02 : 8'h38, a, n, 1'b1);
            end else begin
                logic [7:0] op;
                int s;
                s = int'($urandom % 3);
                if (m_quad) op = (s == 0) ? 8'h0B : 8'hEB;
                else        op = (s == 0) ? 8'h03 : ((s == 1) ? 8'h0B : 8'hEB);
                do_read("R9 random burst R2 R3 R4", op, a, n);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule